// File: doc/BRIEF.md
# CCD Partial-Scan Readout Sequencer

This block produces the digital clock pulses that drive a full-frame CCD when only a horizontal strip of rows is wanted. The strip is always centred vertically on the array, so the middle of the captured image stays on the optical axis of the lens. Rows above the strip are cleared with vertical transfers alone. Their charge falls into the readout register, which is then emptied by a dump pulse and never clocked out horizontally. Because each discarded row costs only one vertical-pulse slot, a narrow strip gives a much shorter frame.

Inside the strip every row is read in full. It gets one vertical transfer and then one horizontal transfer per pixel, and each horizontal transfer is marked by a single-cycle pixel strobe. Rows below the strip are cleared in the same fast way as the rows above it, and then the frame ends with a completion pulse. Columns are never cropped.

A start pulse latches the geometry and the pulse timing for one frame. Outputs are abstract logic pulses. Analog levels and pixel conversion are handled elsewhere.

Top module: `band_scan_seq`

## Requirements
- R1: A start pulse that is high at a clock edge while the block is idle latches all configuration inputs. The first pulse of the frame goes high in cycle 1, counting the cycle after that edge as cycle 0.
- R2: With the effective strip height B taken from R7 and total rows R, the leading discard count is floor((R−B)/2) and the trailing discard count is R−B−floor((R−B)/2). The output order is all leading rows, then the strip, then all trailing rows.
- R3: A discarded row produces one vertical pulse and no horizontal pulse. A dump pulse follows every G-th vertical pulse within a discard phase, and also the last vertical pulse of that phase. A group setting of 0 counts as G=1.
- R4: Each strip row produces one vertical pulse followed by exactly C horizontal pulses, where C is the configured pixels per row. With C=0 a strip row is a single vertical pulse.
- R5: pixel_valid is high for exactly one cycle per horizontal pulse, in that pulse's first high cycle, and at no other time. A frame therefore gives B·C strobes.
- R6: Every vertical, horizontal or dump pulse is high for P consecutive cycles, with a P setting of 0 counting as 1. Consecutive pulses are separated by exactly one low cycle, so pulse n rises in cycle 1+n·(P+1). At most one of the three pulse outputs is high at any time.
- R7: A strip height of 0, or one greater than the row count, is treated as the full frame. In that case no rows are discarded and no dump pulse occurs.
- R8: frame_done is a one-cycle pulse in cycle N·(P+1)+1, where N is the total number of pulses in the frame. An empty frame (R=0) therefore finishes in cycle 1. busy is high from cycle 0 through the frame_done cycle.
- R9: While busy, a start pulse and any change of the configuration inputs have no effect on the pulse stream of the current frame.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frame request, sampled while idle |
| cfg_rows | input | ROW_W | Total rows of the array |
| cfg_cols | input | COL_W | Pixels per row |
| cfg_band | input | ROW_W | Requested strip height |
| cfg_pulse_len | input | PL_W | High time of each pulse in cycles |
| cfg_dump_group | input | GRP_W | Discarded rows per dump pulse |
| v_shift | output | 1 | Vertical transfer pulse |
| h_shift | output | 1 | Horizontal transfer pulse |
| reg_dump | output | 1 | Readout-register clear pulse |
| pixel_valid | output | 1 | One-cycle strobe per read pixel |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |

## Verification
All timing is counted from the clock edge that accepts start, which is cycle 0. The n-th pulse of the frame must rise exactly in cycle 1+n·(P+1), and frame_done must appear in cycle N·(P+1)+1. The driver task builds the expected pulse list from the requirements and stamps each entry with its due cycle. The monitor samples at the falling clock edge, so each registered change made at cycle k's rising edge is observed in cycle k itself. Every rising edge the monitor sees is compared with the head of the queue for both kind and cycle, and every falling edge is checked against the pulse width P. After a frame, the queue must be empty and the strobe and dump totals must match.

// File: rtl/bss_pkg.sv
// Shared types for the partial-scan readout sequencer.
package bss_pkg;
    // Frame progress of the controller.
    typedef enum logic [2:0] {
        PH_IDLE, PH_LEAD, PH_BAND, PH_TRAIL, PH_DONE, PH_FIN
    } phase_t;

    // Kind of pulse slot the timer plays out.
    typedef enum logic [1:0] {
        SK_V, SK_H, SK_D
    } slot_t;

    // Pulse timer state.
    typedef enum logic [1:0] {
        TM_IDLE, TM_HI, TM_GAP
    } tmst_t;
endpackage

// File: rtl/bss_geom.sv
// Strip geometry: clamps the requested strip height and splits the
// remaining rows into a leading and a trailing discard count.
// Assumes: purely combinational, driven by the raw configuration inputs.
module bss_geom #(
    parameter int ROW_W = 12
) (
    input  logic [ROW_W-1:0] rows,
    input  logic [ROW_W-1:0] band_req,
    output logic [ROW_W-1:0] n_lead,
    output logic [ROW_W-1:0] n_band,
    output logic [ROW_W-1:0] n_trail
);
    logic [ROW_W-1:0] spare;

    // Clamp the strip and centre it; the odd leftover row goes to the tail.
    always_comb begin
        if (band_req == '0 || band_req > rows) n_band = rows;
        else                                   n_band = band_req;
        spare   = rows - n_band;
        n_lead  = spare >> 1;
        n_trail = spare - n_lead;
    end
endmodule

// File: rtl/bss_slot_timer.sv
// Pulse timer: plays out one slot at a time as P high cycles followed by
// one low cycle. It accepts the next slot during that low cycle, so
// back-to-back slots keep exactly one low cycle between pulses.
// Assumes: pulse_len is never zero (the controller clamps it).
module bss_slot_timer
    import bss_pkg::*;
#(
    parameter int PL_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  slot_t           kind,
    input  logic [PL_W-1:0] pulse_len,
    output logic            ready,
    output logic            v_out,
    output logic            h_out,
    output logic            d_out,
    output logic            first_hi
);
    tmst_t           st_q;
    slot_t           kind_q;
    logic [PL_W-1:0] cnt_q;
    logic            first_q;

    // Slot state machine: load on go, count down the high time, then gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= TM_IDLE;
            kind_q  <= SK_V;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (go && st_q != TM_HI) begin
            st_q    <= TM_HI;
            kind_q  <= kind;
            cnt_q   <= pulse_len;
            first_q <= 1'b1;
        end else if (st_q == TM_HI) begin
            first_q <= 1'b0;
            if (cnt_q == 1) st_q <= TM_GAP;
            else            cnt_q <= cnt_q - 1'b1;
        end else if (st_q == TM_GAP) begin
            st_q <= TM_IDLE;
        end
    end

    // Decode the registered state onto the pulse lines.
    always_comb begin
        ready    = (st_q != TM_HI);
        v_out    = (st_q == TM_HI) && (kind_q == SK_V);
        h_out    = (st_q == TM_HI) && (kind_q == SK_H);
        d_out    = (st_q == TM_HI) && (kind_q == SK_D);
        first_hi = (st_q == TM_HI) && first_q;
    end

    // R6: a gap cycle is only ever entered straight from a high phase.
    a_r6_gap_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TM_GAP) |-> ($past(st_q) == TM_HI));
endmodule

// File: rtl/bss_ctrl.sv
// Frame controller: latches the configuration at start and walks the
// leading discard rows, the strip rows and the trailing discard rows.
// For each slot it asks the timer for a vertical, horizontal or dump pulse.
// Phases with zero rows are skipped when they are entered, so they cost
// no cycles. Assumes the timer reports ready whenever it can accept a slot.
module bss_ctrl
    import bss_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 12,
    parameter int PL_W  = 4,
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] g_lead,
    input  logic [ROW_W-1:0] g_band,
    input  logic [ROW_W-1:0] g_trail,
    input  logic [COL_W-1:0] cfg_cols,
    input  logic [PL_W-1:0]  cfg_pulse_len,
    input  logic [GRP_W-1:0] cfg_dump_group,
    input  logic             tm_ready,
    output logic             go,
    output slot_t            kind,
    output logic [PL_W-1:0]  pulse_len,
    output logic             busy,
    output logic             frame_done
);
    phase_t           phase_q, nxt_phase, enter_to;
    slot_t            kind_q, nxt_kind;
    logic [ROW_W-1:0] lead_q, band_q, trail_q, cur_cnt;
    logic [ROW_W-1:0] row_idx_q, nxt_row, row_inc;
    logic [COL_W-1:0] ncols_q, col_idx_q, nxt_col, col_inc;
    logic [GRP_W-1:0] grp_eff_q, grp_q, nxt_grp;
    logic [GRP_W:0]   grp_inc;
    logic [PL_W-1:0]  pl_q;
    logic             enter;

    // First phase at or after p that holds rows; DONE when none is left.
    function automatic phase_t pick_phase(input phase_t p,
                                          input logic [ROW_W-1:0] nl,
                                          input logic [ROW_W-1:0] nb,
                                          input logic [ROW_W-1:0] nt);
        phase_t r;
        r = PH_DONE;
        if (p == PH_LEAD && nl != '0)
            r = PH_LEAD;
        else if ((p == PH_LEAD || p == PH_BAND) && nb != '0)
            r = PH_BAND;
        else if ((p == PH_LEAD || p == PH_BAND || p == PH_TRAIL) && nt != '0)
            r = PH_TRAIL;
        return r;
    endfunction

    // Row count of the phase now running.
    always_comb begin
        unique case (phase_q)
            PH_LEAD:  cur_cnt = lead_q;
            PH_BAND:  cur_cnt = band_q;
            default:  cur_cnt = trail_q;
        endcase
    end

    // Slot issue handshake with the timer.
    always_comb begin
        go = tm_ready && (phase_q == PH_LEAD || phase_q == PH_BAND ||
                          phase_q == PH_TRAIL);
    end

    // Next slot after the current one has been issued.
    always_comb begin
        row_inc   = row_idx_q + 1'b1;
        col_inc   = col_idx_q + 1'b1;
        grp_inc   = {1'b0, grp_q} + 1'b1;
        nxt_phase = phase_q;
        nxt_kind  = kind_q;
        nxt_row   = row_idx_q;
        nxt_col   = col_idx_q;
        nxt_grp   = grp_q;
        enter     = 1'b0;
        enter_to  = PH_DONE;
        unique case (phase_q)
            PH_LEAD, PH_TRAIL: begin
                if (kind_q == SK_V) begin
                    nxt_row = row_inc;
                    if (grp_inc == {1'b0, grp_eff_q} || row_inc == cur_cnt) begin
                        nxt_kind = SK_D;
                        nxt_grp  = '0;
                    end else begin
                        nxt_kind = SK_V;
                        nxt_grp  = grp_inc[GRP_W-1:0];
                    end
                end else if (row_idx_q == cur_cnt) begin
                    enter    = 1'b1;
                    enter_to = (phase_q == PH_LEAD) ?
                               pick_phase(PH_BAND, lead_q, band_q, trail_q) : PH_DONE;
                end else begin
                    nxt_kind = SK_V;
                end
            end
            PH_BAND: begin
                if (kind_q == SK_V) begin
                    nxt_row = row_inc;
                    if (ncols_q != '0) begin
                        nxt_kind = SK_H;
                        nxt_col  = '0;
                    end else if (row_inc == band_q) begin
                        enter    = 1'b1;
                        enter_to = pick_phase(PH_TRAIL, lead_q, band_q, trail_q);
                    end
                end else begin
                    nxt_col = col_inc;
                    if (col_inc == ncols_q) begin
                        if (row_idx_q == band_q) begin
                            enter    = 1'b1;
                            enter_to = pick_phase(PH_TRAIL, lead_q, band_q, trail_q);
                        end else begin
                            nxt_kind = SK_V;
                        end
                    end
                end
            end
            default: ;
        endcase
        if (enter) begin
            nxt_phase = enter_to;
            nxt_kind  = SK_V;
            nxt_row   = '0;
            nxt_col   = '0;
            nxt_grp   = '0;
        end
    end

    // Frame sequencing: latch at start, advance per slot, end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            kind_q    <= SK_V;
            lead_q    <= '0;
            band_q    <= '0;
            trail_q   <= '0;
            ncols_q   <= '0;
            grp_eff_q <= '0;
            pl_q      <= '0;
            row_idx_q <= '0;
            col_idx_q <= '0;
            grp_q     <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (start) begin
                lead_q    <= g_lead;
                band_q    <= g_band;
                trail_q   <= g_trail;
                ncols_q   <= cfg_cols;
                grp_eff_q <= (cfg_dump_group == '0) ? GRP_W'(1) : cfg_dump_group;
                pl_q      <= (cfg_pulse_len == '0) ? PL_W'(1) : cfg_pulse_len;
                phase_q   <= pick_phase(PH_LEAD, g_lead, g_band, g_trail);
                kind_q    <= SK_V;
                row_idx_q <= '0;
                col_idx_q <= '0;
                grp_q     <= '0;
            end
        end else if (go) begin
            phase_q   <= nxt_phase;
            kind_q    <= nxt_kind;
            row_idx_q <= nxt_row;
            col_idx_q <= nxt_col;
            grp_q     <= nxt_grp;
        end else if (phase_q == PH_DONE && tm_ready) begin
            phase_q <= PH_FIN;
        end else if (phase_q == PH_FIN) begin
            phase_q <= PH_IDLE;
        end
    end

    // Drive the slot request and the frame status.
    always_comb begin
        kind       = kind_q;
        pulse_len  = pl_q;
        busy       = (phase_q != PH_IDLE);
        frame_done = (phase_q == PH_FIN);
    end

    // R3: discard phases never request a horizontal transfer.
    a_r3_skip_no_h: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (phase_q == PH_LEAD || phase_q == PH_TRAIL)) |-> (kind_q != SK_H));

    // R9: the latched frame settings stay put while a frame runs.
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> ($stable(ncols_q) && $stable(pl_q) &&
                                  $stable(lead_q) && $stable(band_q)));
endmodule

// File: rtl/band_scan_seq.sv
// Top level of the partial-scan readout sequencer. It ties together the
// strip geometry, the frame controller and the pulse timer, and derives the
// pixel strobe from the first high cycle of each horizontal pulse.
// Assumes one frame at a time; start is ignored while busy.
module band_scan_seq
    import bss_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 12,
    parameter int PL_W  = 4,
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [COL_W-1:0] cfg_cols,
    input  logic [ROW_W-1:0] cfg_band,
    input  logic [PL_W-1:0]  cfg_pulse_len,
    input  logic [GRP_W-1:0] cfg_dump_group,
    output logic             v_shift,
    output logic             h_shift,
    output logic             reg_dump,
    output logic             pixel_valid,
    output logic             frame_done,
    output logic             busy
);
    logic [ROW_W-1:0] g_lead, g_band, g_trail;
    logic             tm_ready, go, first_hi;
    slot_t            kind;
    logic [PL_W-1:0]  pulse_len;

    bss_geom #(.ROW_W(ROW_W)) geom_i (
        .rows(cfg_rows), .band_req(cfg_band),
        .n_lead(g_lead), .n_band(g_band), .n_trail(g_trail)
    );

    bss_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .PL_W(PL_W), .GRP_W(GRP_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .g_lead(g_lead), .g_band(g_band), .g_trail(g_trail),
        .cfg_cols(cfg_cols), .cfg_pulse_len(cfg_pulse_len),
        .cfg_dump_group(cfg_dump_group), .tm_ready(tm_ready),
        .go(go), .kind(kind), .pulse_len(pulse_len),
        .busy(busy), .frame_done(frame_done)
    );

    bss_slot_timer #(.PL_W(PL_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .pulse_len(pulse_len),
        .ready(tm_ready), .v_out(v_shift), .h_out(h_shift), .d_out(reg_dump),
        .first_hi(first_hi)
    );

    // Pixel strobe: first high cycle of a horizontal pulse.
    always_comb pixel_valid = h_shift && first_hi;

    // R6: the three transfer lines never overlap.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({v_shift, h_shift, reg_dump}));

    // R6: any pulse starts after a cycle with all transfer lines low.
    a_r6_low_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(v_shift) || $rose(h_shift) || $rose(reg_dump)) |->
        !$past(v_shift || h_shift || reg_dump));

    // R5: the strobe only appears on a horizontal pulse.
    a_r5_strobe_in_h: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_valid |-> h_shift);

    // R8: the end-of-frame pulse lasts one cycle and leaves the block idle.
    a_r8_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !busy));
endmodule

// File: tb/band_scan_seq_tb_top.sv
// Scoreboard bench: the driver task queues each expected pulse with its due
// cycle, and the monitor pops and compares at every falling clock edge.
module band_scan_seq_tb_top;
    localparam int ROW_W = 12, COL_W = 12, PL_W = 4, GRP_W = 4;
    localparam int KV = 0, KH = 1, KD = 2, KF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ROW_W-1:0] cfg_rows = '0, cfg_band = '0;
    logic [COL_W-1:0] cfg_cols = '0;
    logic [PL_W-1:0]  cfg_pulse_len = '0;
    logic [GRP_W-1:0] cfg_dump_group = '0;
    logic v_shift, h_shift, reg_dump, pixel_valid, frame_done, busy;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, t0 = 0, done_off = -1, exp_p = 1;
    bit mon_on = 1'b0;
    int q_kind[$], q_time[$];
    int pv_cnt = 0, d_cnt = 0, ev_in_frame = 0;
    bit pv_prev = 1'b0, pd_prev = 1'b0, ph_prev = 1'b0;
    int run_v = 0, run_h = 0, run_d = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    band_scan_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .PL_W(PL_W), .GRP_W(GRP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_band(cfg_band),
        .cfg_pulse_len(cfg_pulse_len), .cfg_dump_group(cfg_dump_group),
        .v_shift(v_shift), .h_shift(h_shift), .reg_dump(reg_dump),
        .pixel_valid(pixel_valid), .frame_done(frame_done), .busy(busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic string kind_req(input int k);
        case (k)
            KV: return "R2";
            KH: return "R4";
            KD: return "R3";
            default: return "R8";
        endcase
    endfunction

    // Pop the head of the expected queue and compare kind and due cycle.
    task automatic expect_ev(input int k, input int t);
        string req;
        req = (ev_in_frame == 0 && k != KF) ? "R1" : kind_req(k);
        ev_in_frame++;
        if (q_kind.size() == 0) begin
            check(req, "unexpected pulse kind", k, -1);
        end else begin
            check(req, "pulse kind", k, q_kind.pop_front());
            check(req, "pulse due cycle", t, q_time.pop_front());
        end
    endtask

    // Monitor: rising edges against the queue, widths, strobe and busy.
    always @(negedge clk) begin
        if (mon_on) begin
            int t;
            t = cyc - t0;
            check("R8", "busy", int'(busy), int'(t >= 0 && t <= done_off));
            if (v_shift && !pv_prev) expect_ev(KV, t);
            if (h_shift && !ph_prev) expect_ev(KH, t);
            if (reg_dump && !pd_prev) begin expect_ev(KD, t); d_cnt++; end
            if (frame_done) expect_ev(KF, t);
            if (pixel_valid) begin
                pv_cnt++;
                check("R5", "strobe on first high cycle", int'(h_shift && !ph_prev), 1);
            end
            if (!v_shift && pv_prev) check("R6", "vertical width", run_v, exp_p);
            if (!h_shift && ph_prev) check("R6", "horizontal width", run_h, exp_p);
            if (!reg_dump && pd_prev) check("R6", "dump width", run_d, exp_p);
            run_v = v_shift ? run_v + 1 : 0;
            run_h = h_shift ? run_h + 1 : 0;
            run_d = reg_dump ? run_d + 1 : 0;
            pv_prev = v_shift; ph_prev = h_shift; pd_prev = reg_dump;
        end
    end

    // Driver: queue the expected frame, start it, optionally disturb it.
    task automatic run_frame(input int r, input int c, input int b, input int p,
                             input int g, input bit poke);
        int pe, ge, be, lead, trail, n, dumps;
        pe = (p == 0) ? 1 : p;
        ge = (g == 0) ? 1 : g;
        be = (b == 0 || b > r) ? r : b;
        lead = (r - be) / 2;
        trail = r - be - lead;
        n = 0; dumps = 0;
        for (int i = 0; i < lead; i++) begin
            q_kind.push_back(KV); q_time.push_back(1 + n * (pe + 1)); n++;
            if ((i + 1) % ge == 0 || i == lead - 1) begin
                q_kind.push_back(KD); q_time.push_back(1 + n * (pe + 1)); n++; dumps++;
            end
        end
        for (int i = 0; i < be; i++) begin
            q_kind.push_back(KV); q_time.push_back(1 + n * (pe + 1)); n++;
            for (int j = 0; j < c; j++) begin
                q_kind.push_back(KH); q_time.push_back(1 + n * (pe + 1)); n++;
            end
        end
        for (int i = 0; i < trail; i++) begin
            q_kind.push_back(KV); q_time.push_back(1 + n * (pe + 1)); n++;
            if ((i + 1) % ge == 0 || i == trail - 1) begin
                q_kind.push_back(KD); q_time.push_back(1 + n * (pe + 1)); n++; dumps++;
            end
        end
        q_kind.push_back(KF); q_time.push_back(n * (pe + 1) + 1);

        @(negedge clk);
        cfg_rows = ROW_W'(r); cfg_cols = COL_W'(c); cfg_band = ROW_W'(b);
        cfg_pulse_len = PL_W'(p); cfg_dump_group = GRP_W'(g);
        exp_p = pe; pv_cnt = 0; d_cnt = 0; ev_in_frame = 0;
        done_off = n * (pe + 1) + 1;
        t0 = cyc + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            // R9: restart request and new settings while busy
            start = 1'b1;
            cfg_rows = 12'd3; cfg_cols = 12'd1; cfg_band = 12'd1;
            cfg_pulse_len = 4'd5; cfg_dump_group = 4'd7;
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc - t0 <= done_off + 2) @(negedge clk);
        check(poke ? "R9" : "R2", "pulses left in queue", q_kind.size(), 0);
        check("R5", "strobes per frame", pv_cnt, be * c);
        check((lead + trail == 0) ? "R7" : "R3", "dumps per frame", d_cnt, dumps);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet outputs under reset
        check("R10", "outputs in reset",
              int'({v_shift, h_shift, reg_dump, pixel_valid, frame_done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        run_frame(10, 4, 4, 1, 1, 1'b0);   // centred strip, dump every row
        run_frame(11, 3, 4, 2, 2, 1'b1);   // odd spare row, grouped dumps, R9 disturbance
        run_frame(5, 2, 0, 0, 3, 1'b0);    // R7 zero strip, zero pulse length
        run_frame(4, 3, 9, 3, 1, 1'b0);    // R7 oversize strip
        run_frame(0, 3, 0, 1, 1, 1'b0);    // empty frame, R8
        run_frame(6, 0, 2, 1, 0, 1'b0);    // no pixels per row, group zero
        run_frame(7, 2, 6, 1, 4, 1'b0);    // no lead rows, one trail row
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule